// File: doc/BRIEF.md
# Asymmetric-Width Dual-Port Memory

This block is a synchronous dual-port memory whose two ports, A and B, each have a write width and a read width set by their own parameters. All four views share one storage array of fixed capacity. A view's depth is therefore the capacity divided by its width. Each port has one address bus. That bus is sized for the deeper of its two views. The wider view on a port ignores the low address bits that separate narrow words inside one of its wide words.

Data is packed little-endian. Narrow word k inside a wide word at wide address w is the word at narrow address w*ratio + k. It occupies bits [k*narrow_width +: narrow_width] of the wide word. A write through one view can be read back through any other view, with every view seeing the same bits. Reads are registered and always enabled, and have one cycle of latency. Both ports run on a single clock, so the array has exactly one writer process. Simultaneous writes from both ports to overlapping bits leave the affected bits undefined.

The default configuration has these four views over 32768 bits:
- Port A writes 64 bits x 512 and reads 16 bits x 2048, using an 11-bit address.
- Port B writes 256 bits x 128 and reads 32 bits x 1024, using a 10-bit address.

Top module: `asym_dpram`

## Requirements
- R1: Read data appears on a port's read output one clock edge after its address is sampled. It reflects the array contents just before that edge.
- R2: A port-A write (64 bits) ignores the 2 low bits of `a_addr_i`. Address bits [10:2] select the 64-bit word. A port-A read (16 bits) uses all 11 bits.
- R3: A port-B write (256 bits) ignores the 3 low bits of `b_addr_i`. Bits [9:3] select the 256-bit word. A port-B read (32 bits) uses all 10 bits. A B write leaves every other B word untouched.
- R4: Packing is little-endian. 16-bit read word k of the 64-bit A word at address w is at A read address 4w+k, in bits [16k+15:16k]. 32-bit B read address j holds A read addresses 2j (low half) and 2j+1 (high half).
- R5: 256-bit B word w holds 64-bit A words 4w to 4w+3, with the lowest-numbered word in the lowest bits. Its 16-bit slice k is A read address 16w+k.
- R6: A read and a write on the same port in the same cycle, touching the same location, return the old contents (read-first).
- R7: A read on one port in the same cycle as a write to the same location on the other port returns the old contents.
- R8: While `rst_ni` is low, both read outputs are zero.
- R9: With no write in the previous cycle and an unchanged address, a read output holds its value.
- R10: With a write enable low, that port's write data has no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers |
| a_addr_i | input | A_AW (11) | Port A address, in read-view units when the read view is deeper |
| a_we_i | input | 1 | Port A write enable |
| a_wdata_i | input | A_WR_W (64) | Port A write data |
| a_rdata_o | output | A_RD_W (16) | Port A registered read data |
| b_addr_i | input | B_AW (10) | Port B address |
| b_we_i | input | 1 | Port B write enable |
| b_wdata_i | input | B_WR_W (256) | Port B write data |
| b_rdata_o | output | B_RD_W (32) | Port B registered read data |

## Verification
Four properties are checked on every cycle. On each port, a write followed by a read whose base lands on the same narrow entry must return the written bits two edges later. On each port, a read output must hold when its address is unchanged and no write occurred in the previous cycle. Little-endian placement across views and the discarded low address bits of the wide views need the bench scenarios. The same holds for read-first ordering within a port and across ports, and for ignored data under a low write enable. Those scenarios compare each read against a bit-level model of the shared storage and against fixed expected words.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asym_dpram_addr.sv
// Maps a port address onto the base index of the narrow-entry array
module asym_dpram_addr #(
  parameter int PORT_AW    = 11,
  parameter int IF_W       = 64,
  parameter int TOTAL_BITS = 32768,
  parameter int EAW        = 11
) (
  input  logic [PORT_AW-1:0] addr_i,
  output logic [EAW-1:0]     base_o
);

  localparam int IF_AW = $clog2(TOTAL_BITS / IF_W);
  localparam int DROP  = PORT_AW - IF_AW;  // low bits ignored by this view
  localparam int PACK  = EAW - IF_AW;      // log2 of entries per word

  logic [IF_AW-1:0] word_idx;
  assign word_idx = addr_i[PORT_AW-1:DROP];

  generate
    if (DROP > 0) begin : g_drop
      logic unused_low;
      assign unused_low = ^addr_i[DROP-1:0];
    end
    if (PACK == 0) begin : g_narrow
      assign base_o = word_idx;
    end else begin : g_wide
      assign base_o = {word_idx, {PACK{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/asym_dpram_core.sv
// Narrow-entry storage with two multi-entry write ports and two registered read ports
module asym_dpram_core #(
  parameter int NW    = 16,
  parameter int EAW   = 11,
  parameter int WA_W  = 64,
  parameter int RA_W  = 16,
  parameter int WB_W  = 256,
  parameter int RB_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wa_en_i,
  input  logic [EAW-1:0]  wa_base_i,
  input  logic [WA_W-1:0] wa_data_i,
  input  logic [EAW-1:0]  ra_base_i,
  output logic [RA_W-1:0] ra_data_o,
  input  logic            wb_en_i,
  input  logic [EAW-1:0]  wb_base_i,
  input  logic [WB_W-1:0] wb_data_i,
  input  logic [EAW-1:0]  rb_base_i,
  output logic [RB_W-1:0] rb_data_o
);

  localparam int DEPTH = 1 << EAW;
  localparam int WA_N  = WA_W / NW;
  localparam int RA_N  = RA_W / NW;
  localparam int WB_N  = WB_W / NW;
  localparam int RB_N  = RB_W / NW;

  logic [NW-1:0]   mem_q [DEPTH];
  logic [RA_W-1:0] ra_next;
  logic [RB_W-1:0] rb_next;

  // Port B is applied last: overlapping same-cycle writes are undefined
  always_ff @(posedge clk_i) begin
    if (wa_en_i) begin
      for (int k = 0; k < WA_N; k++) begin
        mem_q[wa_base_i + EAW'(k)] <= wa_data_i[k*NW +: NW];
      end
    end
    if (wb_en_i) begin
      for (int k = 0; k < WB_N; k++) begin
        mem_q[wb_base_i + EAW'(k)] <= wb_data_i[k*NW +: NW];
      end
    end
  end

  generate
    for (genvar k = 0; k < RA_N; k++) begin : g_ra
      assign ra_next[k*NW +: NW] = mem_q[ra_base_i + EAW'(k)];
    end
    for (genvar k = 0; k < RB_N; k++) begin : g_rb
      assign rb_next[k*NW +: NW] = mem_q[rb_base_i + EAW'(k)];
    end
  endgenerate

  // Read-first: old contents are captured on the write edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_data_o <= '0;
      rb_data_o <= '0;
    end else begin
      ra_data_o <= ra_next;
      rb_data_o <= rb_next;
    end
  end

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter int A_WR_W     = 64,
  parameter int A_RD_W     = 16,
  parameter int B_WR_W     = 256,
  parameter int B_RD_W     = 32,
  parameter int TOTAL_BITS = 32768,
  parameter int A_AW       = $clog2(TOTAL_BITS / min_of(A_WR_W, A_RD_W)),
  parameter int B_AW       = $clog2(TOTAL_BITS / min_of(B_WR_W, B_RD_W))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [A_AW-1:0]   a_addr_i,
  input  logic              a_we_i,
  input  logic [A_WR_W-1:0] a_wdata_i,
  output logic [A_RD_W-1:0] a_rdata_o,
  input  logic [B_AW-1:0]   b_addr_i,
  input  logic              b_we_i,
  input  logic [B_WR_W-1:0] b_wdata_i,
  output logic [B_RD_W-1:0] b_rdata_o
);

  localparam int NW  = min_of(min_of(A_WR_W, A_RD_W), min_of(B_WR_W, B_RD_W));
  localparam int EAW = $clog2(TOTAL_BITS / NW);
  localparam int MA  = min_of(A_WR_W, A_RD_W);
  localparam int MB  = min_of(B_WR_W, B_RD_W);

  logic [EAW-1:0] a_wr_base, a_rd_base, b_wr_base, b_rd_base;

  asym_dpram_addr #(.PORT_AW(A_AW), .IF_W(A_WR_W), .TOTAL_BITS(TOTAL_BITS), .EAW(EAW))
    u_a_wr (.addr_i(a_addr_i), .base_o(a_wr_base));
  asym_dpram_addr #(.PORT_AW(A_AW), .IF_W(A_RD_W), .TOTAL_BITS(TOTAL_BITS), .EAW(EAW))
    u_a_rd (.addr_i(a_addr_i), .base_o(a_rd_base));
  asym_dpram_addr #(.PORT_AW(B_AW), .IF_W(B_WR_W), .TOTAL_BITS(TOTAL_BITS), .EAW(EAW))
    u_b_wr (.addr_i(b_addr_i), .base_o(b_wr_base));
  asym_dpram_addr #(.PORT_AW(B_AW), .IF_W(B_RD_W), .TOTAL_BITS(TOTAL_BITS), .EAW(EAW))
    u_b_rd (.addr_i(b_addr_i), .base_o(b_rd_base));

  asym_dpram_core #(
    .NW(NW), .EAW(EAW),
    .WA_W(A_WR_W), .RA_W(A_RD_W), .WB_W(B_WR_W), .RB_W(B_RD_W)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wa_en_i  (a_we_i),
    .wa_base_i(a_wr_base),
    .wa_data_i(a_wdata_i),
    .ra_base_i(a_rd_base),
    .ra_data_o(a_rdata_o),
    .wb_en_i  (b_we_i),
    .wb_base_i(b_wr_base),
    .wb_data_i(b_wdata_i),
    .rb_base_i(b_rd_base),
    .rb_data_o(b_rdata_o)
  );

  // Edges since reset release, saturating; gates history-based properties
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_wr_rd_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(a_we_i) && !$past(b_we_i) && a_rd_base == $past(a_wr_base))
    |=> a_rdata_o[MA-1:0] == $past(a_wdata_i[MA-1:0], 2));

  p_wr_rd_b_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(b_we_i) && !$past(a_we_i) && b_rd_base == $past(b_wr_base))
    |=> b_rdata_o[MB-1:0] == $past(b_wdata_i[MB-1:0], 2));

  p_hold_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(a_we_i) && !$past(b_we_i) && a_addr_i == $past(a_addr_i))
    |=> $stable(a_rdata_o));

  p_hold_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !$past(a_we_i) && !$past(b_we_i) && b_addr_i == $past(b_addr_i))
    |=> $stable(b_rdata_o));

endmodule

// File: tb/sim_asym_dpram.sv
module sim_asym_dpram;
  localparam int AWW = 64, ARW = 16, BWW = 256, BRW = 32, TOT = 32768;
  localparam int AAW = 11, BAW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AAW-1:0] a_addr = '0;
  logic           a_we   = 1'b0;
  logic [AWW-1:0] a_wd   = '0;
  logic [ARW-1:0] a_rd;
  logic [BAW-1:0] b_addr = '0;
  logic           b_we   = 1'b0;
  logic [BWW-1:0] b_wd   = '0;
  logic [BRW-1:0] b_rd;

  asym_dpram u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(a_addr), .a_we_i(a_we), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_addr_i(b_addr), .b_we_i(b_we), .b_wdata_i(b_wd), .b_rdata_o(b_rd)
  );

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R8";

  bit [TOT-1:0]   ref_bits = '0;
  logic [ARW-1:0] exp_a = '0;
  logic [BRW-1:0] exp_b = '0;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Behavioural model: read old bits, then apply writes (A word = addr/4, B word = addr/8)
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_a = '0;
      exp_b = '0;
    end else begin
      exp_a = ref_bits[int'(a_addr) * ARW +: ARW];
      exp_b = ref_bits[int'(b_addr) * BRW +: BRW];
      if (a_we) ref_bits[(int'(a_addr) / 4) * AWW +: AWW] = a_wd;
      if (b_we) ref_bits[(int'(b_addr) / 8) * BWW +: BWW] = b_wd;
    end
    #1;
    chk({cur_req, " model port A"}, 256'(a_rd), 256'(exp_a));
    chk({cur_req, " model port B"}, 256'(b_rd), 256'(exp_b));
  end

  task automatic cyc(input logic awe, input logic [AAW-1:0] aad, input logic [AWW-1:0] awd,
                     input logic bwe, input logic [BAW-1:0] bad, input logic [BWW-1:0] bwd);
    @(negedge clk);
    a_we = awe; a_addr = aad; a_wd = awd;
    b_we = bwe; b_addr = bad; b_wd = bwd;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [BWW-1:0] pat;
    a_addr = 11'd5; b_addr = 10'd7;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset A", 256'(a_rd), 256'h0);
    chk("R8 reset B", 256'(b_rd), 256'h0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R3";
    for (int w = 0; w < 128; w++) cyc(1'b0, '0, '0, 1'b1, BAW'(w * 8), '0);

    cur_req = "R2";
    cyc(1'b1, 11'd3, 64'h4444_3333_2222_1111, 1'b0, '0, '0);
    cyc(1'b0, 11'd0, '0, 1'b0, 10'd0, '0);
    chk("R2 A write at addr 3 lands in word 0", 256'(a_rd), 256'h1111);
    chk("R4 B read addr 0", 256'(b_rd), 256'h2222_1111);
    cyc(1'b0, 11'd1, '0, 1'b0, 10'd1, '0);
    chk("R4 A read addr 1", 256'(a_rd), 256'h2222);
    chk("R4 B read addr 1", 256'(b_rd), 256'h4444_3333);
    cyc(1'b0, 11'd3, '0, 1'b0, 10'd0, '0);
    chk("R4 A read addr 3", 256'(a_rd), 256'h4444);

    cur_req = "R5";
    for (int k = 0; k < 16; k++) pat[k*16 +: 16] = 16'hB000 + 16'(k);
    cyc(1'b0, 11'd0, '0, 1'b1, 10'd13, pat);
    chk("R1 A read concurrent with B write", 256'(a_rd), 256'h1111);
    cyc(1'b0, 11'd16, '0, 1'b0, 10'd9, '0);
    chk("R5 A read addr 16", 256'(a_rd), 256'hB000);
    chk("R5 B read addr 9", 256'(b_rd), 256'hB003_B002);
    cyc(1'b0, 11'd21, '0, 1'b0, 10'd0, '0);
    chk("R3 B write at addr 13 lands in word 1", 256'(a_rd), 256'hB005);
    chk("R3 B word 0 untouched", 256'(b_rd), 256'h2222_1111);

    cur_req = "R6";
    cyc(1'b1, 11'd0, 64'h8888_7777_6666_5555, 1'b0, 10'd0, '0);
    chk("R6 A read-first", 256'(a_rd), 256'h1111);
    cyc(1'b0, 11'd0, '0, 1'b0, 10'd0, '0);
    chk("R6 A new data", 256'(a_rd), 256'h5555);

    cur_req = "R7";
    cyc(1'b0, 11'd16, '0, 1'b1, 10'd8, {16{16'hCCCC}});
    chk("R7 A old data during B write", 256'(a_rd), 256'hB000);
    cyc(1'b0, 11'd16, '0, 1'b0, 10'd0, '0);
    chk("R7 A new data", 256'(a_rd), 256'hCCCC);

    cur_req = "R9";
    cyc(1'b0, 11'd16, '0, 1'b0, 10'd0, '0);
    chk("R9 A hold", 256'(a_rd), 256'hCCCC);
    chk("R9 B hold", 256'(b_rd), 256'h6666_5555);

    cur_req = "R10";
    cyc(1'b0, 11'd0, {64{1'b1}}, 1'b0, 10'd0, {256{1'b1}});
    cyc(1'b0, 11'd0, '0, 1'b0, 10'd0, '0);
    chk("R10 A unchanged", 256'(a_rd), 256'h5555);
    chk("R10 B unchanged", 256'(b_rd), 256'h6666_5555);

    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      cyc(sel == 1, AAW'($urandom), {$urandom, $urandom},
          sel == 2, BAW'($urandom), {8{$urandom}});
    end

    cyc(1'b0, '0, '0, 1'b0, '0, '0);
    finish_run();
  end

endmodule